// File: doc/BRIEF.md
# Multi-Frame Receive Byte Queue with Frame Rollback

This block buffers received bytes in a shared 128-byte ring. Several complete frames can sit in it at once. The receiver writes bytes one at a time. It then gives a one-cycle verdict for the frame it is writing: accept keeps the bytes, drop throws them away. A drop removes only the bytes written since the last accept. Frames that were already accepted stay in place and can still be read.

The read side is a show-ahead byte port. A DMA engine or a processor drains it, and it only ever shows accepted bytes. Three status signals describe the queue: a not-empty level, a ready level with a one-cycle rising pulse that serves as interrupt request and DMA trigger, and a sticky overflow flag. All status describes this receive queue only, whatever the radio is doing. A flush input empties everything.

Inside, the block keeps two write positions. One marks the end of accepted data and the other the end of the frame in progress. An accept moves the first position up to the second, and a drop moves the second back to the first.

Top module: `rxq_frame_fifo`

## Requirements
- R1: After reset, not_empty, frame_rdy, frame_rdy_pulse and overflow are 0, and rd_data is 0.
- R2: Bytes of an accepted frame are presented on rd_data in the order they were written. rd_data shows the oldest unread accepted byte, and each rd_en cycle advances it. not_empty is 1 in the cycle after the accept.
- R3: Bytes of a frame that has not been accepted are invisible. While no accepted byte is unread, not_empty is 0, rd_data is 0 and rd_en has no effect.
- R4: frame_drop discards every byte written since the last accept, including a byte written in the same cycle, while earlier accepted frames stay readable. When frame_drop and frame_ok are high together, the drop wins.
- R5: Total storage is DEPTH (128) bytes shared by any number of frames. DEPTH bytes written as several frames and accepted are all read back in order without overflow.
- R6: With a nonzero rdy_thresh, frame_rdy is 1 while the number of held bytes (accepted plus in progress) is at least rdy_thresh. A value of 0 disables this term.
- R7: frame_rdy is also 1 while at least one complete accepted frame has unread bytes. It falls once the last byte of the last such frame is read.
- R8: frame_rdy_pulse is 1 for exactly the one cycle in which frame_rdy rises.
- R9: A write while DEPTH bytes are held is not stored and sets overflow. overflow stays set and blocks all later writes until a flush.
- R10: While overflow is set, frame_ok acts as frame_drop, so the truncated frame is discarded.
- R11: flush empties the queue, discards committed and pending bytes, and clears overflow. Writes are accepted again in the next cycle.
- R12: A byte written in the same cycle as frame_ok belongs to the accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Write one byte of the frame in progress |
| wr_data | input | W | Byte to write |
| frame_ok | input | 1 | Accept the frame in progress |
| frame_drop | input | 1 | Discard the frame in progress |
| flush | input | 1 | Empty the queue and clear overflow |
| rd_en | input | 1 | Consume the byte shown on rd_data |
| rd_data | output | W | Oldest unread accepted byte, 0 when none |
| rdy_thresh | input | $clog2(DEPTH)+1 | Held-byte threshold for frame_rdy, 0 disables |
| not_empty | output | 1 | At least one accepted byte unread |
| frame_rdy | output | 1 | Threshold reached or complete frame present |
| frame_rdy_pulse | output | 1 | One-cycle pulse on the rise of frame_rdy |
| overflow | output | 1 | Sticky write-into-full flag |

## Verification
The bench builds the block with its defaults: 8-bit bytes and a 128-byte ring. This makes the exact full boundary reachable with a few hundred writes, so the ring is filled to its last slot by several frames and then pushed one byte past it. Those runs exercise pointer wraparound, the overflow block, and the accept-turned-drop at the point where a correct and a wrong count differ by a single byte. Small thresholds such as 4 make the threshold crossing and its single pulse show up a few writes after a frame begins.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // One cycle's worth of commands seen by the pointer unit
  typedef struct packed {
    logic wr;
    logic rd;
    logic acc;
    logic rej;
    logic fl;
  } rxq_req_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_raw,
  input  logic          rd_fire,
  input  logic          mark_set,
  input  logic [AW-1:0] mark_addr,
  input  logic          flush,
  output logic          mark_at_rd
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] mark_q, mark_d;

  // Byte array: data only, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_raw     = mem[rd_addr];
  assign mark_at_rd = mark_q[rd_addr];

  // End-of-frame marks: set on accept, cleared when the byte is consumed
  always_comb begin
    mark_d = mark_q;
    if (rd_fire)  mark_d[rd_addr]   = 1'b0;
    if (mark_set) mark_d[mark_addr] = 1'b1;
    if (flush)    mark_d            = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mark_q <= '0;
    else        mark_q <= mark_d;
  end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
  import rxq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rxq_req_t      req,
  input  logic          mark_at_rd,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_fire,
  output logic          mark_set,
  output logic [AW-1:0] mark_addr,
  output logic [CW-1:0] commit_cnt,
  output logic [CW-1:0] held_cnt,
  output logic [CW-1:0] frame_cnt,
  output logic          ovf
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] step_dn(input logic [AW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  logic [AW-1:0] rp_q, rp_d, cwp_q, cwp_d, swp_q, swp_d, swp_w;
  logic [CW-1:0] ccnt_q, ccnt_d, tcnt_q, tcnt_d, fcnt_q, fcnt_d;
  logic [CW-1:0] tcnt_w, ccnt_r;
  logic          ovf_q, ovf_d;
  logic          live, wr_ok, do_wr, ovf_hit, do_rd, rej_eff, acc_eff;

  always_comb begin
    live    = !req.fl;
    wr_ok   = live && req.wr && !ovf_q;
    do_wr   = wr_ok && (tcnt_q != FULL);
    ovf_hit = wr_ok && (tcnt_q == FULL);
    do_rd   = live && req.rd && (ccnt_q != '0);
    rej_eff = live && (req.rej || (req.acc && ovf_q));
    acc_eff = live && req.acc && !req.rej && !ovf_q;

    swp_w  = do_wr ? step_up(swp_q) : swp_q;
    tcnt_w = tcnt_q + CW'(do_wr) - CW'(do_rd);
    ccnt_r = ccnt_q - CW'(do_rd);

    rp_d     = do_rd ? step_up(rp_q) : rp_q;
    cwp_d    = cwp_q;
    swp_d    = swp_w;
    ccnt_d   = ccnt_r;
    tcnt_d   = tcnt_w;
    ovf_d    = ovf_q || ovf_hit;
    mark_set = 1'b0;

    if (rej_eff) begin
      swp_d  = cwp_q;
      tcnt_d = ccnt_r;
    end else if (acc_eff) begin
      cwp_d    = swp_w;
      ccnt_d   = tcnt_w;
      mark_set = (tcnt_w != ccnt_r);
    end

    fcnt_d = fcnt_q + CW'(mark_set) - CW'(do_rd && mark_at_rd);

    if (req.fl) begin
      rp_d   = '0;
      cwp_d  = '0;
      swp_d  = '0;
      ccnt_d = '0;
      tcnt_d = '0;
      fcnt_d = '0;
      ovf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q   <= '0;
      cwp_q  <= '0;
      swp_q  <= '0;
      ccnt_q <= '0;
      tcnt_q <= '0;
      fcnt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      rp_q   <= rp_d;
      cwp_q  <= cwp_d;
      swp_q  <= swp_d;
      ccnt_q <= ccnt_d;
      tcnt_q <= tcnt_d;
      fcnt_q <= fcnt_d;
      ovf_q  <= ovf_d;
    end
  end

  assign wr_en      = do_wr;
  assign wr_addr    = swp_q;
  assign rd_addr    = rp_q;
  assign rd_fire    = do_rd;
  assign mark_addr  = step_dn(swp_w);
  assign commit_cnt = ccnt_q;
  assign held_cnt   = tcnt_q;
  assign frame_cnt  = fcnt_q;
  assign ovf        = ovf_q;
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int W  = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] commit_cnt,
  input  logic [CW-1:0] held_cnt,
  input  logic [CW-1:0] frame_cnt,
  input  logic [CW-1:0] thresh,
  input  logic [W-1:0]  rd_raw,
  output logic [W-1:0]  rd_data,
  output logic          not_empty,
  output logic          rdy,
  output logic          rdy_pulse
);
  logic rdy_q;

  always_comb begin
    not_empty = (commit_cnt != '0);
    rd_data   = not_empty ? rd_raw : '0;
    rdy       = ((thresh != '0) && (held_cnt >= thresh)) || (frame_cnt != '0);
    rdy_pulse = rdy && !rdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy;
  end
endmodule

// File: rtl/rxq_frame_fifo.sv
module rxq_frame_fifo
  import rxq_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  input  logic          frame_ok,
  input  logic          frame_drop,
  input  logic          flush,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  input  logic [CW-1:0] rdy_thresh,
  output logic          not_empty,
  output logic          frame_rdy,
  output logic          frame_rdy_pulse,
  output logic          overflow
);
  logic [1:0]    rst_sync;
  logic          rst_core_n;
  rxq_req_t      req;
  logic          wr_en, rd_fire, mark_set, mark_at_rd;
  logic [AW-1:0] wr_addr, rd_addr, mark_addr;
  logic [CW-1:0] commit_cnt, held_cnt, frame_cnt;
  logic [W-1:0]  rd_raw;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign req = '{wr: wr_valid, rd: rd_en, acc: frame_ok, rej: frame_drop, fl: flush};

  rxq_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk(clk), .rst_n(rst_core_n), .req(req), .mark_at_rd(mark_at_rd),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_fire(rd_fire),
    .mark_set(mark_set), .mark_addr(mark_addr), .commit_cnt(commit_cnt),
    .held_cnt(held_cnt), .frame_cnt(frame_cnt), .ovf(overflow)
  );

  rxq_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_raw(rd_raw), .rd_fire(rd_fire),
    .mark_set(mark_set), .mark_addr(mark_addr), .flush(flush),
    .mark_at_rd(mark_at_rd)
  );

  rxq_flags #(.W(W), .CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_core_n), .commit_cnt(commit_cnt),
    .held_cnt(held_cnt), .frame_cnt(frame_cnt), .thresh(rdy_thresh),
    .rd_raw(rd_raw), .rd_data(rd_data), .not_empty(not_empty),
    .rdy(frame_rdy), .rdy_pulse(frame_rdy_pulse)
  );
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic          wr_valid,
  input logic          frame_ok,
  input logic          frame_drop,
  input logic          flush,
  input logic          rd_en,
  input logic [W-1:0]  rd_data,
  input logic          not_empty,
  input logic          frame_rdy,
  input logic          frame_rdy_pulse,
  input logic          overflow,
  input logic [CW-1:0] held_cnt
);
  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    flush |=> (!not_empty && !overflow && held_cnt == '0));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (overflow && !flush) |=> overflow);

  // R9
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_valid && !overflow && !flush && !rd_en && held_cnt == CW'(DEPTH))
      |=> (overflow && held_cnt == CW'(DEPTH)));

  // R3
  hidden_data_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !not_empty |-> (rd_data == '0));

  // R4
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (frame_drop && !flush && !rd_en) |=> $stable(not_empty));

  // R10
  ovf_accept_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (frame_ok && overflow && !flush && !rd_en) |=> $stable(not_empty));

  // R8
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    frame_rdy_pulse == $rose(frame_rdy));
endmodule

bind rxq_frame_fifo rxq_fifo_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .wr_valid(wr_valid),
  .frame_ok(frame_ok), .frame_drop(frame_drop), .flush(flush),
  .rd_en(rd_en), .rd_data(rd_data), .not_empty(not_empty),
  .frame_rdy(frame_rdy), .frame_rdy_pulse(frame_rdy_pulse),
  .overflow(overflow), .held_cnt(held_cnt)
);

// File: tb/sim_rxq_frame_fifo.sv
module sim_rxq_frame_fifo;
  localparam int W     = 8;
  localparam int DEPTH = 128;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid, frame_ok, frame_drop, flush, rd_en;
  logic [W-1:0]  wr_data, rd_data;
  logic [CW-1:0] rdy_thresh;
  logic          not_empty, frame_rdy, frame_rdy_pulse, overflow;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rxq_frame_fifo #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .frame_ok(frame_ok), .frame_drop(frame_drop), .flush(flush),
    .rd_en(rd_en), .rd_data(rd_data), .rdy_thresh(rdy_thresh),
    .not_empty(not_empty), .frame_rdy(frame_rdy),
    .frame_rdy_pulse(frame_rdy_pulse), .overflow(overflow)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [W-1:0] b);
    wr_valid = 1'b1; wr_data = b;
    tick;
    wr_valid = 1'b0;
  endtask

  task automatic accept;
    frame_ok = 1'b1;
    tick;
    frame_ok = 1'b0;
  endtask

  task automatic drop;
    frame_drop = 1'b1;
    tick;
    frame_drop = 1'b0;
  endtask

  task automatic pop(input string req, input int exp);
    eq(req, "rd_data", int'(rd_data), exp);
    rd_en = 1'b1;
    tick;
    rd_en = 1'b0;
  endtask

  task automatic do_flush;
    flush = 1'b1;
    tick;
    flush = 1'b0;
  endtask

  task automatic t_reset;
    eq("R1", "not_empty", int'(not_empty), 0);
    eq("R1", "frame_rdy", int'(frame_rdy), 0);
    eq("R1", "frame_rdy_pulse", int'(frame_rdy_pulse), 0);
    eq("R1", "overflow", int'(overflow), 0);
    eq("R1", "rd_data", int'(rd_data), 0);
  endtask

  task automatic t_basic;
    push(8'h11); push(8'h22); push(8'h33);
    eq("R3", "not_empty pending", int'(not_empty), 0);
    eq("R3", "rd_data pending", int'(rd_data), 0);
    rd_en = 1'b1; tick; rd_en = 1'b0;   // R3: read while nothing committed
    accept;
    eq("R2", "not_empty after accept", int'(not_empty), 1);
    eq("R7", "frame_rdy with frame", int'(frame_rdy), 1);
    pop("R2", 8'h11); pop("R2", 8'h22); pop("R2", 8'h33);
    eq("R2", "not_empty drained", int'(not_empty), 0);
    eq("R7", "frame_rdy drained", int'(frame_rdy), 0);
  endtask

  task automatic t_reject;
    push(8'hA0); push(8'hA1); accept;
    push(8'hB0); push(8'hB1); push(8'hB2);
    drop;
    eq("R4", "not_empty kept", int'(not_empty), 1);
    // R12: byte written together with accept
    wr_valid = 1'b1; wr_data = 8'hC0; frame_ok = 1'b1;
    tick;
    wr_valid = 1'b0; frame_ok = 1'b0;
    // R4: drop beats accept, same-cycle byte dropped too
    push(8'hD0);
    wr_valid = 1'b1; wr_data = 8'hD1; frame_ok = 1'b1; frame_drop = 1'b1;
    tick;
    wr_valid = 1'b0; frame_ok = 1'b0; frame_drop = 1'b0;
    pop("R4", 8'hA0); pop("R4", 8'hA1);
    pop("R12", 8'hC0);
    eq("R4", "not_empty after kept frames", int'(not_empty), 0);
    eq("R7", "frame_rdy after kept frames", int'(frame_rdy), 0);
  endtask

  task automatic t_thresh;
    rdy_thresh = CW'(4);
    push(8'h01); push(8'h02); push(8'h03);
    eq("R6", "frame_rdy below thresh", int'(frame_rdy), 0);
    push(8'h04);
    eq("R6", "frame_rdy at thresh", int'(frame_rdy), 1);
    eq("R8", "pulse on rise", int'(frame_rdy_pulse), 1);
    eq("R3", "not_empty pending at thresh", int'(not_empty), 0);
    tick;
    eq("R8", "pulse one cycle", int'(frame_rdy_pulse), 0);
    eq("R6", "frame_rdy held", int'(frame_rdy), 1);
    drop;
    eq("R6", "frame_rdy after drop", int'(frame_rdy), 0);
    rdy_thresh = '0;
  endtask

  task automatic t_fill;
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < DEPTH / 4; i++) push(W'(f * (DEPTH / 4) + i + 1));
      accept;
    end
    eq("R5", "overflow at full", int'(overflow), 0);
    eq("R5", "not_empty at full", int'(not_empty), 1);
    for (int i = 0; i < DEPTH; i++) pop("R5", (i + 1) & 8'hFF);
    eq("R5", "not_empty after drain", int'(not_empty), 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 100; i++) push(W'(i));
    accept;
    for (int i = 0; i < DEPTH - 100; i++) push(8'h99);
    eq("R9", "no overflow at exact full", int'(overflow), 0);
    push(8'hEE);
    eq("R9", "overflow on write into full", int'(overflow), 1);
    accept;   // R10: acts as drop
    for (int i = 0; i < 100; i++) pop("R10", i);
    eq("R10", "truncated frame gone", int'(not_empty), 0);
    push(8'h55); tick;
    eq("R9", "overflow sticky", int'(overflow), 1);
    accept;
    eq("R9", "write blocked while overflow", int'(not_empty), 0);
    do_flush;
    eq("R11", "overflow cleared", int'(overflow), 0);
    push(8'h77); accept;
    eq("R11", "writes resume", int'(not_empty), 1);
    pop("R11", 8'h77);
  endtask

  task automatic t_flush;
    push(8'h61); push(8'h62); accept;
    push(8'h63);
    rdy_thresh = CW'(2);
    do_flush;
    eq("R11", "not_empty after flush", int'(not_empty), 0);
    eq("R11", "frame_rdy after flush", int'(frame_rdy), 0);
    eq("R11", "rd_data after flush", int'(rd_data), 0);
    rdy_thresh = '0;
    push(8'h64); accept;
    pop("R11", 8'h64);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; frame_ok = 1'b0;
    frame_drop = 1'b0; flush = 1'b0; rd_en = 1'b0; rdy_thresh = '0;
    repeat (3) tick;
    rst_n = 1'b1;
    repeat (3) tick;
    t_reset;
    t_basic;
    t_reject;
    t_thresh;
    t_fill;
    t_overflow;
    t_flush;
    finish_run;
  end
endmodule